// File: doc/BRIEF.md
# Masked Interrupt Coalescing Controller

This block is the interrupt unit of a device. It keeps a register of cause bits and a register of mask bits, and it drives one level-sensitive interrupt line towards the CPU. Sources inside the device post cause bits. Software clears cause bits, rewrites the mask, sets a global enable and acknowledges the line. Bus decode and register addressing sit outside the block.

When a post leaves a cause both set and unmasked, the line is normally raised only after a programmable number of clock cycles. This lets a burst of events share one interrupt. A post that arrives while a countdown is already running cannot push that deadline later. It can only pull the deadline earlier. Some causes belong to an urgent class and raise the line at once. Only one CPU interrupt is outstanding at any time. The line stays high until software acknowledges it, clears the causes, masks them off or turns the enable off.

Top module: `irq_coalesce`

## Requirements
- R1: A post ORs `post_vec` into `status` on the next edge. A clear removes the bits of `clear_vec` on that edge. When a post and a clear arrive in the same cycle, the clear is applied first, so the posted bits end up set.
- R2: A post or clear vector that touches a reserved cause bit (bits 7 and 6) is dropped as a whole. `err` is then high for exactly the one cycle after the attempt, and reserved status bits never become set.
- R3: After reset, `status` is 0, `mask` is 0x26 (bit 1 RX data, bit 2 RX FIFO threshold, bit 5 TX FIFO threshold), and `irq` and `err` are low.
- R4: With the enable on, a post that leaves `status & mask` nonzero, with no urgent bit among the masked pending causes, makes `irq` rise on the `delay_cfg`-th edge after the edge that records the post. A `delay_cfg` of 0 raises it on the same edge.
- R5: Causes 2 and 5 form the urgent class. A post that leaves any of them both pending and unmasked raises `irq` on the same edge that records the post.
- R6: A delayed request whose deadline falls at or after a running countdown leaves that countdown unchanged. A request with an earlier deadline replaces it.
- R7: `cpu_ack` lowers `irq` on the next edge and does not raise it again by itself. A later deadline or urgent post raises it again.
- R8: A clear that leaves `status & mask` at zero lowers `irq` on that edge and cancels any running countdown. A clear that leaves some masked cause pending does not disturb the countdown.
- R9: A mask write equal to the current mask has no effect. A different mask raises `irq` at once if `status & mask` becomes nonzero. If it becomes zero, the write lowers `irq` and cancels the countdown.
- R10: While `enable` is low, no interrupt is scheduled and `irq` is low from the edge after it falls. On the edge where `enable` rises with `status & mask` nonzero, `irq` rises.
- R11: `irq` is never high while `status & mask` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_vec | input | 8 | Cause bits to set this cycle |
| clear_vec | input | 8 | Cause bits to clear this cycle |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask value |
| enable | input | 1 | Global interrupt enable (level) |
| delay_cfg | input | 8 | Coalescing delay in clock cycles |
| cpu_ack | input | 1 | CPU acknowledge, lowers the line |
| irq | output | 1 | Level interrupt to the CPU |
| status | output | 8 | Cause status readback |
| mask | output | 8 | Mask readback |
| err | output | 1 | One-cycle flag for a rejected reserved-bit access |

## Verification
Some properties hold on every cycle and are checked by assertions:
- the line never stands without a masked pending cause;
- the line is quiet while the enable is low;
- an acknowledge drops the line;
- an urgent post raises the line on the next cycle;
- a running countdown only ever steps down by one, unless a reload makes it earlier;
- a reserved-bit access raises the error flag.

Other behaviour can only be shown by the bench's scenarios, because it depends on exact arrival times. This covers the exact rise cycle for each cause and delay, whether a second post replaces or keeps a deadline, cancellation by clear or mask, and the fact that an equal mask write changes nothing.

// File: rtl/irqc_pkg.sv
// Shared types for the interrupt coalescing controller.
// Assumes: nothing beyond IEEE 1800-2017.
package irqc_pkg;

    // Scheduling command that the top-level glue hands to the timer and the line.
    typedef struct packed {
        logic now;   // raise the line on this edge
        logic load;  // request a delayed deadline
        logic drop;  // cancel any running countdown
    } sched_t;

endpackage

// File: rtl/irqc_cause_regs.sv
// Cause status and mask registers with reserved-bit protection.
// Computes the next-state view (status_nx & mask_nx) that scheduling decides on.
// Assumes: RSV marks bits that may never be posted or cleared.
module irqc_cause_regs #(
    parameter int unsigned NC = 8,
    parameter logic [NC-1:0] RSV = 8'hC0,
    parameter logic [NC-1:0] RST_MASK = 8'h26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] post_vec,
    input  logic [NC-1:0] clear_vec,
    input  logic          mask_we,
    input  logic [NC-1:0] mask_wdata,
    output logic [NC-1:0] status_q,
    output logic [NC-1:0] mask_q,
    output logic          err_q,
    output logic          post_hit,
    output logic          clear_hit,
    output logic          mask_diff,
    output logic [NC-1:0] pend_nx
);
    logic          post_bad, clr_bad;
    logic [NC-1:0] post_ok, clr_ok, status_nx, mask_nx;

    // Screen the request vectors and form the next register values.
    always_comb begin
        post_bad  = |(post_vec & RSV);
        clr_bad   = |(clear_vec & RSV);
        post_ok   = post_bad ? '0 : post_vec;
        clr_ok    = clr_bad ? '0 : clear_vec;
        post_hit  = |post_ok;
        clear_hit = |clr_ok;
        mask_diff = mask_we && (mask_wdata != mask_q);
        status_nx = (status_q & ~clr_ok) | post_ok;
        mask_nx   = mask_diff ? mask_wdata : mask_q;
        pend_nx   = status_nx & mask_nx;
    end

    // Register status, mask and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= RST_MASK;
            err_q    <= 1'b0;
        end else begin
            status_q <= status_nx;
            mask_q   <= mask_nx;
            err_q    <= post_bad | clr_bad;
        end
    end

    assert_rsv_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & RSV) == '0);
    assert_reject_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|((post_vec | clear_vec) & RSV)) |=> err_q);
endmodule

// File: rtl/irqc_deadline.sv
// Coalescing countdown: zero means idle, one means the deadline is this edge.
// A load only takes effect when it is earlier than the running deadline.
// Assumes: load is never requested with a delay of zero (the glue raises at once instead).
module irqc_deadline #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] delay,
    input  logic          drop,
    output logic          expire
);
    logic [DW-1:0] cnt;

    // Flag the edge on which the running deadline is due.
    always_comb expire = (cnt == DW'(1));

    // Count down, reload on an earlier request, clear on cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (drop) begin
            cnt <= '0;
        end else if (load && (cnt == '0 || delay < cnt)) begin
            cnt <= delay;
        end else if (cnt != '0) begin
            cnt <= cnt - DW'(1);
        end
    end

    assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !drop && (!load || delay >= cnt)) |=> cnt == $past(cnt) - DW'(1));
    assert_no_later_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !drop) |=> cnt < $past(cnt));
endmodule

// File: rtl/irqc_line.sv
// Single outstanding CPU interrupt line, plus edge detection on the enable.
// Priority per edge: withdraw/enable-off, then fire, then acknowledge.
// Assumes: fire is only requested while a masked cause is pending.
module irqc_line (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fire,
    input  logic withdraw,
    input  logic ack,
    output logic irq,
    output logic en_rise,
    output logic en_fall
);
    logic en_q;

    // Detect enable transitions against the last sampled value.
    always_comb begin
        en_rise = enable & ~en_q;
        en_fall = ~enable & en_q;
    end

    // Hold the outstanding interrupt; a second fire while high changes nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            en_q <= 1'b0;
        end else begin
            en_q <= enable;
            if (withdraw || !enable) irq <= 1'b0;
            else if (fire)           irq <= 1'b1;
            else if (ack)            irq <= 1'b0;
        end
    end

    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq);
    assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fire) |=> !irq);
endmodule

// File: rtl/irq_coalesce.sv
// Masked interrupt coalescing controller, top level.
// Decides per cycle whether to raise at once, request a delayed deadline or
// withdraw the line, based on the next-state masked causes.
// Assumes: inputs are synchronous to clk; software decodes its own registers.
module irq_coalesce #(
    parameter int unsigned NC = 8,
    parameter int unsigned DW = 8,
    parameter logic [NC-1:0] RSV = 8'hC0,
    parameter logic [NC-1:0] URGENT = 8'h24,
    parameter logic [NC-1:0] RST_MASK = 8'h26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] post_vec,
    input  logic [NC-1:0] clear_vec,
    input  logic          mask_we,
    input  logic [NC-1:0] mask_wdata,
    input  logic          enable,
    input  logic [DW-1:0] delay_cfg,
    input  logic          cpu_ack,
    output logic          irq,
    output logic [NC-1:0] status,
    output logic [NC-1:0] mask,
    output logic          err
);
    import irqc_pkg::*;

    logic          post_hit, clear_hit, mask_diff;
    logic [NC-1:0] pend_nx;
    logic          any_pend, urgent_pend, withdraw, expire, en_rise, en_fall;
    sched_t        cmd;

    irqc_cause_regs #(.NC(NC), .RSV(RSV), .RST_MASK(RST_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .clear_vec(clear_vec),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .status_q(status),
        .mask_q(mask), .err_q(err), .post_hit(post_hit), .clear_hit(clear_hit),
        .mask_diff(mask_diff), .pend_nx(pend_nx)
    );

    // Turn this cycle's events into one scheduling command.
    always_comb begin
        any_pend    = |pend_nx;
        urgent_pend = |(pend_nx & URGENT);
        withdraw    = !any_pend && (clear_hit || mask_diff);
        cmd.now     = enable && any_pend &&
                      ((post_hit && (urgent_pend || delay_cfg == '0)) ||
                       mask_diff || en_rise);
        cmd.load    = enable && any_pend && post_hit && !cmd.now;
        cmd.drop    = withdraw || cmd.now || !enable;
    end

    irqc_deadline #(.DW(DW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(cmd.load), .delay(delay_cfg),
        .drop(cmd.drop), .expire(expire)
    );

    irqc_line u_line (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fire(cmd.now | expire),
        .withdraw(withdraw), .ack(cpu_ack), .irq(irq),
        .en_rise(en_rise), .en_fall(en_fall)
    );

    assert_line_needs_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |(status & mask));
    assert_urgent_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && post_hit && urgent_pend) |=> irq);
    assert_rise_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(enable));
    assert_fall_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !irq);
endmodule

// File: tb/irq_coalesce_test.sv
`timescale 1ns/1ps
module irq_coalesce_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] post = '0, clr = '0, mwd = '0, dly = '0;
    logic       mwe = 1'b0, en = 1'b1, ack = 1'b0;
    logic       irq, err;
    logic [7:0] status, mask;
    int         n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    irq_coalesce uut (
        .clk(clk), .rst_n(rst_n), .post_vec(post), .clear_vec(clr),
        .mask_we(mwe), .mask_wdata(mwd), .enable(en), .delay_cfg(dly),
        .cpu_ack(ack), .irq(irq), .status(status), .mask(mask), .err(err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask
    task automatic do_post(input logic [7:0] v); post = v; tick(); post = '0; endtask
    task automatic do_clear(input logic [7:0] v); clr = v; tick(); clr = '0; endtask
    task automatic do_mask(input logic [7:0] v); mwe = 1'b1; mwd = v; tick(); mwe = 1'b0; endtask
    task automatic do_ack(); ack = 1'b1; tick(); ack = 1'b0; endtask
    task automatic wait_rise(output int n);
        n = 0;
        while (!irq && n < 64) begin tick(); n++; end
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        tick(); tick(); tick();
        // R3 reset state
        check("R3 status", status, 0);
        check("R3 mask", mask, 8'h26);
        check("R3 irq", irq, 0);
        check("R3 err", err, 0);
        rst_n = 1'b1;
        tick();

        // R4/R5 sweep over causes and delays
        do_mask(8'h3F);
        for (int b = 0; b < 6; b++) begin
            for (int d = 0; d < 7; d++) begin
                dly = 8'(d);
                do_post(8'(1 << b));
                check("R1 sweep status", status, 1 << b);
                wait_rise(n);
                check((b == 2 || b == 5) ? "R5 urgent rise" : "R4 delayed rise",
                      n, (b == 2 || b == 5 || d == 0) ? 0 : d);
                do_clear(8'h3F);
                check("R8 clear drops", irq, 0);
            end
        end

        // R6 later request keeps the running deadline
        dly = 8'd3; post = 8'h01; tick();
        dly = 8'd20; post = 8'h08; tick(); post = '0;
        wait_rise(n);
        check("R6 later kept", n, 2);
        do_clear(8'h3F);
        // R6 earlier request replaces it
        dly = 8'd10; post = 8'h01; tick();
        dly = 8'd2; post = 8'h08; tick(); post = '0;
        wait_rise(n);
        check("R6 earlier replaces", n, 2);
        do_clear(8'h3F);

        // R7 ack and re-raise
        dly = 8'd4;
        do_post(8'h04);
        check("R5 urgent", irq, 1);
        do_post(8'h01);
        check("R7 still one line", irq, 1);
        do_ack();
        check("R7 ack drops", irq, 0);
        repeat (6) tick();
        check("R7 stays low", irq, 0);
        do_clear(8'h04);
        do_post(8'h08);
        wait_rise(n);
        check("R7 re-raise after ack", n, 4);
        do_clear(8'h3F);

        // R8 clear to zero cancels; partial clear keeps the countdown
        dly = 8'd6;
        do_post(8'h01); tick();
        do_clear(8'h01);
        wait_rise(n);
        check("R8 cancelled", n, 64);
        dly = 8'd5;
        do_post(8'h09); tick();
        do_clear(8'h01);
        wait_rise(n);
        check("R8 partial keeps", n, 3);
        do_clear(8'h3F);

        // R9 mask writes
        do_mask(8'h26);
        dly = 8'd3;
        do_post(8'h01);
        repeat (5) tick();
        check("R9 unmasked quiet", irq, 0);
        do_mask(8'h26); tick();
        check("R9 equal no effect", irq, 0);
        do_mask(8'h27);
        check("R9 differ raises", irq, 1);
        do_ack();
        do_mask(8'h27); tick(); tick();
        check("R9 equal no re-raise", irq, 0);
        do_mask(8'h2F);
        check("R9 differ raises again", irq, 1);
        do_mask(8'h26);
        check("R9 zero drops", irq, 0);
        do_clear(8'h3F);

        // R10 enable
        do_mask(8'h3F);
        en = 1'b0; tick();
        do_post(8'h04);
        repeat (3) tick();
        check("R10 off no irq", irq, 0);
        en = 1'b1; tick();
        check("R10 rise posts", irq, 1);
        en = 1'b0; tick();
        check("R10 fall clears", irq, 0);
        en = 1'b1;
        do_clear(8'h3F);

        // R2 reserved bits
        do_post(8'h41);
        check("R2 err post", err, 1);
        check("R2 post rejected", status, 0);
        tick();
        check("R2 err one cycle", err, 0);
        do_post(8'h01);
        do_clear(8'h81);
        check("R2 err clear", err, 1);
        check("R2 clear rejected", status, 1);

        // R1 or/and-not and same-cycle order
        do_post(8'h05);
        check("R1 or", status, 5);
        do_clear(8'h01);
        check("R1 and-not", status, 4);
        post = 8'h02; clr = 8'h02; tick(); post = '0; clr = '0;
        check("R1 post after clear", status, 6);
        check("R11 irq with cause", irq, 1);
        do_clear(8'h3F);
        check("R11 no cause no irq", irq, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule